// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets logic in a clocked domain read and write an external asynchronous static RAM of 32K bytes. A single-word request port carries an address, a write flag and write data under a valid/ready handshake. The controller drives the RAM's active-low select, write strobe and read strobe. It also controls the direction of the shared data bus and returns read data with a one-cycle completion pulse.

The RAM's timing limits are given as nanosecond parameters. Each one becomes a whole number of clock cycles by rounding up against the clock-period parameter, with a floor of one cycle. Writes always run with the read strobe high. The controller waits for the RAM's output to float before it turns its own drivers on, and it keeps data, address and select steady until after the write strobe has risen. Requests may follow each other with no idle cycle, provided the minimum cycle time from one access start to the next has elapsed.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, select, write strobe and read strobe are high, the bus drivers are off, `req_ready` is 1 and `rsp_done` is 0.
- R2: A read drops select and the read strobe on the edge that accepts the request, with the write strobe high. The byte on `dq_i` is captured RD cycles later, where RD = ceil(max(address access, select access, read-strobe access)/clock). `rsp_done` is 1 for the cycle in which `rsp_rdata` first shows that byte (9 cycles after acceptance with default values).
- R3: A write holds the write strobe low for WR = ceil(max(select-to-end, address-setup-to-end, strobe width, data setup)/clock) cycles (8 by default). Write data on `dq_o` stays stable while the strobe is low and one cycle past its rising edge. `rsp_done` follows TURN+WR+1 cycles after acceptance (13 by default).
- R4: The read strobe is high whenever `dq_oe` is 1. `dq_oe` rises no earlier than TURN = ceil(output-float time/clock) edges after the read strobe last rose (4 by default).
- R5: The address is stable for every cycle in which select is low. Select returns high on the edge that raises `rsp_done`.
- R6: `req_ready` is low from the accepting edge until the access ends. Two consecutive select-falling edges are at least RC = ceil(max(read cycle, write cycle)/clock) cycles apart (9 by default).
- R7: Every nanosecond limit is turned into a cycle count by rounding up against `CLK_NS`, with a floor of one. The latencies in R2 and R3 follow from these counts.
- R8: The write strobe is low only while select is low, and the write and read strobes are never low together.
- R9: `rsp_done` lasts exactly one cycle per access. A write leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| ram_addr | output | 15 | RAM address lines |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM read strobe, active low |
| dq_o | output | 8 | Data driven toward the RAM |
| dq_oe | output | 1 | Enable for the data pad drivers |
| dq_i | input | 8 | Data received from the RAM pads |

## Verification
The assertions assume a synchronous reset at start-up and a request port that keeps address, write flag and data steady on the accepting edge. They also assume the pad logic turns `dq_oe` directly into bus direction. The bench changes request fields only on falling edges and raises `req_valid` only when it has sampled `req_ready` high. Its RAM model returns a poison byte until the read strobe has been low for the full access time. Addresses come from a small pool that includes both ends of the address space, so reads often hit locations written earlier.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD     = 3'd1,
    S_TURN   = 3'd2,
    S_WPULSE = 3'd3,
    S_WHOLD  = 3'd4,
    S_GAP    = 3'd5
  } seq_state_t;

  // Round a nanosecond limit up to whole clock cycles, at least one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_down_timer.sv
module asram_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  p_timer_counts_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && $past(!load) && $past(cnt) != '0 && !$past(rst)) |-> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/asram_pace.sv
module asram_pace #(
  parameter int RC_CYC = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rc_met
);
  localparam int W      = $clog2(RC_CYC + 1) + 1;
  localparam int RC_THR = (RC_CYC >= 2) ? RC_CYC - 2 : 0;

  logic [W-1:0] elapsed;

  // elapsed holds (edges since start - 1), saturating at RC_CYC
  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= W'(RC_CYC);
    end else if (start) begin
      elapsed <= '0;
    end else if (elapsed < W'(RC_CYC)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // met means the next edge may accept a new access start
  assign rc_met = (elapsed >= W'(RC_THR));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int TW     = 4,
  parameter int RD_CYC = 9,
  parameter int WR_CYC = 8,
  parameter int TN_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          t_zero,
  input  logic          rc_met,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          accept,
  output logic          capture,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          drive,
  output logic          ready,
  output logic          done
);
  localparam logic [TW-1:0] RD_LD = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] WR_LD = TW'(WR_CYC - 1);
  localparam logic [TW-1:0] TN_LD = TW'(TN_CYC - 1);

  seq_state_t state;

  assign accept  = (state == S_IDLE) && req_valid && ready;
  assign capture = (state == S_RD) && t_zero;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept) begin
      t_load = 1'b1;
      t_val  = req_write ? TN_LD : RD_LD;
    end else if (state == S_TURN && t_zero) begin
      t_load = 1'b1;
      t_val  = WR_LD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drive <= 1'b0;
      ready <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            ready <= 1'b0;
            ce_n  <= 1'b0;
            if (req_write) begin
              state <= S_TURN;
            end else begin
              oe_n  <= 1'b0;
              state <= S_RD;
            end
          end
        end
        S_RD: begin
          if (t_zero) begin
            oe_n <= 1'b1;
            ce_n <= 1'b1;
            done <= 1'b1;
            if (rc_met) begin
              ready <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_GAP;
            end
          end
        end
        S_TURN: begin
          if (t_zero) begin
            we_n  <= 1'b0;
            drive <= 1'b1;
            state <= S_WPULSE;
          end
        end
        S_WPULSE: begin
          if (t_zero) begin
            we_n  <= 1'b1;
            state <= S_WHOLD;
          end
        end
        S_WHOLD: begin
          drive <= 1'b0;
          ce_n  <= 1'b1;
          done  <= 1'b1;
          if (rc_met) begin
            ready <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_GAP;
          end
        end
        S_GAP: begin
          if (rc_met) begin
            ready <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_state_legal_r6: assert property (@(posedge clk) disable iff (rst)
    state inside {S_IDLE, S_RD, S_TURN, S_WPULSE, S_WHOLD, S_GAP});

  p_drive_after_turn_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> ($past(state) == S_TURN));

endmodule

// File: rtl/asram_dq.sv
module asram_dq #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      dq_o     <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        ram_addr <= req_addr;
        dq_o     <= req_wdata;
      end
      if (capture) begin
        rdata <= dq_i;
      end
    end
  end

  p_rdata_only_on_capture_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(capture) && !$past(rst)) |-> $stable(rdata));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS    = 8,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int T_RC_NS   = 70,
  parameter int T_WC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_ACE_NS  = 70,
  parameter int T_DOE_NS  = 35,
  parameter int T_SCE_NS  = 60,
  parameter int T_AW_NS   = 60,
  parameter int T_PWE_NS  = 50,
  parameter int T_SD_NS   = 30,
  parameter int T_HZOE_NS = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int RD_CYC = ns_to_cyc(imax(T_AA_NS, imax(T_ACE_NS, T_DOE_NS)), CLK_NS);
  localparam int WR_CYC = ns_to_cyc(imax(imax(T_SCE_NS, T_AW_NS), imax(T_PWE_NS, T_SD_NS)), CLK_NS);
  localparam int TN_CYC = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int RC_CYC = ns_to_cyc(imax(T_RC_NS, T_WC_NS), CLK_NS);
  localparam int TW     = $clog2(imax(RD_CYC, imax(WR_CYC, TN_CYC)) + 1) + 1;

  logic          t_load, t_zero, rc_met, accept, capture;
  logic [TW-1:0] t_val;

  asram_down_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  asram_pace #(.RC_CYC(RC_CYC)) u_pace (
    .clk(clk), .rst(rst), .start(accept), .rc_met(rc_met)
  );

  asram_seq #(
    .TW(TW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TN_CYC(TN_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .t_zero(t_zero), .rc_met(rc_met), .t_load(t_load), .t_val(t_val),
    .accept(accept), .capture(capture), .ce_n(ram_ce_n), .we_n(ram_we_n),
    .oe_n(ram_oe_n), .drive(dq_oe), .ready(req_ready), .done(rsp_done)
  );

  asram_dq #(.AW(ADDR_W), .DW(DATA_W)) u_dq (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_i(dq_i),
    .ram_addr(ram_addr), .dq_o(dq_o), .rdata(rsp_rdata)
  );

  p_we_inside_ce_r8: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n);

  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(!ram_we_n && !ram_oe_n));

  p_drive_oe_high_r4: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> ram_oe_n);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |-> !req_ready);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_wdata_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(dq_o));

  p_drive_past_we_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> dq_oe);

  p_release_ce_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> ram_ce_n);

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int CLK = 8;

  function automatic int up(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_EXP = up(70);
  localparam int WR_EXP = up(60);
  localparam int TN_EXP = up(25);
  localparam int RC_EXP = up(70);
  localparam int WR_LAT = TN_EXP + WR_EXP + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, req_valid, req_ready, req_write, rsp_done;
  logic [14:0] req_addr, ram_addr;
  logic [7:0] req_wdata, rsp_rdata, dq_o, dq_i;
  logic ram_ce_n, ram_we_n, ram_oe_n, dq_oe;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [7:0] ram_mem [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] exp_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 8'h5A;
  endfunction

  // RAM model and pin monitors, sampled on falling edges
  int rd_age = 0, cyc = 0, last_start = -1000, we_run = 0, oe_hi = 100;
  logic prev_ce = 1'b1, prev_we = 1'b1, prev_oe_drv = 1'b0, prev_done = 1'b0;
  logic [14:0] start_addr = '0;

  always @(posedge clk) begin
    if (ram_oe_n || ram_ce_n) rd_age <= 0;
    else rd_age <= rd_age + 1;
  end

  always @(negedge clk) begin
    if (!ram_ce_n && ram_we_n && !ram_oe_n && rd_age >= RD_EXP - 1)
      dq_i <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h5A;
    else
      dq_i <= 8'hEE;
    if (!rst) begin
      cyc++;
      if (prev_ce && !ram_ce_n) begin
        chk(cyc - last_start >= RC_EXP, "R6 start spacing", cyc - last_start, RC_EXP);
        last_start = cyc;
        start_addr = ram_addr;
      end else if (!ram_ce_n) begin
        chk(ram_addr == start_addr, "R5 address stable", ram_addr, start_addr);
      end
      if (!ram_ce_n) chk(!req_ready, "R6 ready low while busy", req_ready, 0);
      if (!ram_we_n) begin
        we_run++;
        chk(!ram_ce_n && ram_oe_n, "R8 strobe decode", {ram_ce_n, ram_oe_n}, 2'b01);
      end
      if (!prev_we && ram_we_n) begin
        chk(we_run == WR_EXP, "R3 strobe width", we_run, WR_EXP);
        chk(dq_oe && !ram_ce_n, "R3 data held past strobe", {dq_oe, ram_ce_n}, 2'b10);
        if (!ram_ce_n) ram_mem[int'(ram_addr)] = dq_o;
        we_run = 0;
      end
      if (ram_oe_n) oe_hi++;
      else oe_hi = 0;
      if (dq_oe && !prev_oe_drv)
        chk(oe_hi >= TN_EXP + 1, "R4 turnaround", oe_hi, TN_EXP + 1);
      if (dq_oe) chk(ram_oe_n, "R4 drive with read strobe high", ram_oe_n, 1);
      if (prev_done && rsp_done) chk(0, "R9 done single cycle", 1, 0);
      if (rsp_done) chk(ram_ce_n, "R5 select released with done", ram_ce_n, 1);
      prev_ce = ram_ce_n;
      prev_we = ram_we_n;
      prev_oe_drv = dq_oe;
      prev_done = rsp_done;
    end
  end

  task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int lat;
    logic [7:0] prev_rd;
    while (!req_ready) @(negedge clk);
    prev_rd   = rsp_rdata;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 ready drops on accept", req_ready, 0);
    lat = 0;
    while (!rsp_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    if (wr) begin
      shadow[int'(a)] = d;
      chk(lat == WR_LAT, "R3 R7 write latency", lat, WR_LAT);
      chk(rsp_rdata == prev_rd, "R9 rdata kept on write", rsp_rdata, prev_rd);
    end else begin
      chk(lat == RD_EXP, "R2 R7 read latency", lat, RD_EXP);
      chk(rsp_rdata == exp_rd(int'(a)), "R2 read data", rsp_rdata, exp_rd(int'(a)));
    end
  endtask

  function automatic logic [14:0] pool(input int i);
    if (i == 0) return 15'h0000;
    if (i == 15) return 15'h7FFF;
    return 15'((i * 32'h0A3D + 32'h11) & 32'h7FFF);
  endfunction

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    rst = 1'b1;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ram_ce_n && ram_we_n && ram_oe_n && !dq_oe, "R1 strobes idle", {ram_ce_n, ram_we_n, ram_oe_n, dq_oe}, 4'b1110);
    chk(req_ready && !rsp_done, "R1 ready and done", {req_ready, rsp_done}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && !dq_oe && req_ready, "R1 after release",
        {ram_ce_n, ram_we_n, ram_oe_n, dq_oe, req_ready}, 5'b11101);
    // directed corners
    do_req(1'b0, 15'h1234, 8'h00);   // unwritten location
    do_req(1'b1, 15'h0000, 8'h3C);
    do_req(1'b1, 15'h7FFF, 8'hC3);
    do_req(1'b0, 15'h0000, 8'h00);
    do_req(1'b0, 15'h7FFF, 8'h00);
    do_req(1'b1, 15'h2AAA, 8'hFF);
    do_req(1'b0, 15'h2AAA, 8'h00);   // read right after write
    do_req(1'b1, 15'h2AAA, 8'h01);   // write right after read
    do_req(1'b0, 15'h2AAA, 8'h00);
    for (int n = 0; n < 400; n++) begin
      do_req(1'($urandom % 2), pool(int'($urandom % 16)), 8'($urandom));
    end
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule